// File: doc/BRIEF.md
# Streaming Ten-Channel Phase-Shift Beamformer MAC

This block combines the outputs of a ten-element receive array into one complex beamformed stream. On each cycle with the input valid high, it takes one complex sample from every channel. It also takes a complex steering weight for every channel. Each sample is multiplied by the conjugate of its weight. The ten products are added in a pipelined tree, then rounded and saturated to a 16-bit complex result.

The steering weights come from a separate generator whose latency is 36 cycles. So the block delays the data by 36 cycles, and each sample meets the weights that the generator produces for it. The weights for a sample are presented 36 cycles after the sample itself. The multiply-accumulate section then takes 19 register stages:
- an alignment register,
- a product register,
- a complex-combine register,
- one register per adder-tree level,
- a rounding register,
- a run of tail delays.

In total, a result leaves the block 55 cycles after its data entered. Only the valid pipeline is reset. The data registers run freely.

Top module: `beam_mac`

## Requirements
- R1: `out_vld` is high in cycle c+55 exactly when `in_vld` was high in cycle c. Back-to-back valids and gaps in the input pattern are reproduced unchanged at the output.
- R2: The weights on `w_re`/`w_im` are applied to the data that was presented 36 cycles earlier. Weight values in any other cycle have no effect on that result.
- R3: The result is computed at full precision before rounding, as sums over the ten channels:
  - real part = Σ(xr·wr + xi·wi)
  - imaginary part = Σ(xi·wr − xr·wi)
- R4: Rounding adds 2^13 to the full-precision sum, then shifts it arithmetically right by 14 bits. Halves therefore round toward +infinity. For example, a sum of 8192 gives 1, a sum of −8192 gives 0 and a sum of −8193 gives −1.
- R5: A rounded value above 32767 is output as 32767. A rounded value below −32768 is output as −32768.
- R6: The reset is synchronous and active high. It clears every pipeline valid, so `out_vld` stays low for 55 cycles after reset is released, even if valid samples entered before the reset.
- R7: While `out_vld` is low, `out_re` and `out_im` are zero.
- R8: The field layouts are as follows:
  - Channel k's data occupies bits [12k+11:12k] of `in_re`/`in_im`, as signed 12-bit values.
  - Channel k's weight occupies bits [16k+15:16k] of `w_re`/`w_im`, as signed 16-bit values with 14 fraction bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_vld | input | 1 | High when the data buses carry a sample set |
| in_re | input | 120 | Real parts of the ten channel samples, 12 bits each |
| in_im | input | 120 | Imaginary parts of the ten channel samples |
| w_re | input | 160 | Real parts of the ten steering weights, 16 bits each |
| w_im | input | 160 | Imaginary parts of the ten steering weights |
| out_vld | output | 1 | High when the beamformed result is valid |
| out_re | output | 16 | Real part of the beamformed sample |
| out_im | output | 16 | Imaginary part of the beamformed sample |

## Verification
Every result is due exactly 55 cycles after its data was driven. The weights for that sample are driven 36 cycles after the data, and the weight bus carries random values in every other cycle, so a misalignment corrupts the result.

The bench runs one loop per scenario. Each loop iteration sits at a falling clock edge. It first compares the outputs with the expectation for the sample driven 55 iterations earlier, then drives the data for the current slot and the weights for the slot 36 iterations back. Each loop runs 57 cycles past its last sample, so the pipeline drains before the next scenario.

After a reset that cuts a stream short, every one of the next 60 cycles is checked for a low valid and zero data.

// File: rtl/beam_mac.sv
module beam_mac #(
  parameter int NCH     = 10,
  parameter int DW      = 12,
  parameter int WW      = 16,
  parameter int OW      = 16,
  parameter int SHIFT   = 14,
  parameter int GUARD   = 4,
  parameter int PRE_DLY = 36,
  parameter int MAC_DLY = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [NCH*DW-1:0] in_re,
  input  logic [NCH*DW-1:0] in_im,
  input  logic [NCH*WW-1:0] w_re,
  input  logic [NCH*WW-1:0] w_im,
  output logic              out_vld,
  output logic [OW-1:0]     out_re,
  output logic [OW-1:0]     out_im
);
  localparam int LAT  = PRE_DLY + MAC_DLY;
  localparam int LVL  = $clog2(NCH);
  localparam int NP   = 1 << LVL;
  localparam int MW   = DW + WW;
  localparam int SW   = MW + 1 + GUARD;
  localparam int TAIL = MAC_DLY - (LVL + 4);
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (SHIFT - 1);
  localparam logic signed [SW-1:0] HI   = (SW'(1) <<< (OW - 1)) - SW'(1);
  localparam logic signed [SW-1:0] LO   = -HI - SW'(1);

  logic [LAT-1:0] vp;
  always_ff @(posedge clk)
    if (rst) vp <= '0;
    else     vp <= {vp[LAT-2:0], in_vld};
  assign out_vld = vp[LAT-1];

  logic [NCH*DW-1:0] d_re, d_im;
  generate
    if (PRE_DLY > 0) begin : g_pre
      logic [NCH*DW-1:0] sr_re [PRE_DLY];
      logic [NCH*DW-1:0] sr_im [PRE_DLY];
      always_ff @(posedge clk) begin
        sr_re[0] <= in_re;
        sr_im[0] <= in_im;
        for (int i = 1; i < PRE_DLY; i++) begin
          sr_re[i] <= sr_re[i-1];
          sr_im[i] <= sr_im[i-1];
        end
      end
      assign d_re = sr_re[PRE_DLY-1];
      assign d_im = sr_im[PRE_DLY-1];
    end else begin : g_nopre
      assign d_re = in_re;
      assign d_im = in_im;
    end
  endgenerate

  logic [NCH*DW-1:0] a_re, a_im;
  logic [NCH*WW-1:0] a_wr, a_wi;
  always_ff @(posedge clk) begin
    a_re <= d_re;
    a_im <= d_im;
    a_wr <= w_re;
    a_wi <= w_im;
  end

  logic signed [MW-1:0] p_rr [NCH];
  logic signed [MW-1:0] p_ii [NCH];
  logic signed [MW-1:0] p_ir [NCH];
  logic signed [MW-1:0] p_ri [NCH];
  logic signed [SW-1:0] t_re [2*NP-1];
  logic signed [SW-1:0] t_im [2*NP-1];

  generate
    for (genvar c = 0; c < NP; c++) begin : g_leaf
      if (c < NCH) begin : g_ch
        always_ff @(posedge clk) begin
          p_rr[c] <= $signed(a_re[c*DW +: DW]) * $signed(a_wr[c*WW +: WW]);
          p_ii[c] <= $signed(a_im[c*DW +: DW]) * $signed(a_wi[c*WW +: WW]);
          p_ir[c] <= $signed(a_im[c*DW +: DW]) * $signed(a_wr[c*WW +: WW]);
          p_ri[c] <= $signed(a_re[c*DW +: DW]) * $signed(a_wi[c*WW +: WW]);
          t_re[NP-1+c] <= SW'(p_rr[c]) + SW'(p_ii[c]);
          t_im[NP-1+c] <= SW'(p_ir[c]) - SW'(p_ri[c]);
        end
      end else begin : g_pad
        always_ff @(posedge clk) begin
          t_re[NP-1+c] <= '0;
          t_im[NP-1+c] <= '0;
        end
      end
    end
    for (genvar k = 0; k < NP - 1; k++) begin : g_node
      always_ff @(posedge clk) begin
        t_re[k] <= t_re[2*k+1] + t_re[2*k+2];
        t_im[k] <= t_im[2*k+1] + t_im[2*k+2];
      end
    end
  endgenerate

  function automatic logic [OW-1:0] clip(input logic signed [SW-1:0] v);
    if (v > HI)      return HI[OW-1:0];
    else if (v < LO) return LO[OW-1:0];
    else             return v[OW-1:0];
  endfunction

  logic signed [SW-1:0] r_re, r_im;
  assign r_re = (t_re[0] + HALF) >>> SHIFT;
  assign r_im = (t_im[0] + HALF) >>> SHIFT;

  logic [OW-1:0] q_re, q_im, z_re, z_im;
  always_ff @(posedge clk) begin
    q_re <= clip(r_re);
    q_im <= clip(r_im);
  end

  generate
    if (TAIL > 0) begin : g_tail
      logic [OW-1:0] tl_re [TAIL];
      logic [OW-1:0] tl_im [TAIL];
      always_ff @(posedge clk) begin
        tl_re[0] <= q_re;
        tl_im[0] <= q_im;
        for (int i = 1; i < TAIL; i++) begin
          tl_re[i] <= tl_re[i-1];
          tl_im[i] <= tl_im[i-1];
        end
      end
      assign z_re = tl_re[TAIL-1];
      assign z_im = tl_im[TAIL-1];
    end else begin : g_notail
      assign z_re = q_re;
      assign z_im = q_im;
    end
  endgenerate

  assign out_re = out_vld ? z_re : '0;
  assign out_im = out_vld ? z_im : '0;
endmodule

// File: rtl/beam_mac_chk.sv
module beam_mac_chk #(
  parameter int LAT = 55,
  parameter int OW  = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic          out_vld,
  input logic [OW-1:0] out_re,
  input logic [OW-1:0] out_im
);
  localparam int CW = $clog2(LAT + 1) + 1;
  logic [CW-1:0] pend, age;

  always_ff @(posedge clk)
    if (rst) begin
      pend <= '0;
      age  <= '0;
    end else begin
      pend <= pend + CW'(in_vld) - CW'(out_vld);
      if (age < CW'(LAT)) age <= age + CW'(1);
    end

  p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (age < CW'(LAT)) |-> !out_vld);
  p_out_has_source_r1: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (pend != '0));
  p_inflight_bound_r1: assert property (@(posedge clk) disable iff (rst)
    pend <= CW'(LAT));
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (out_re == '0 && out_im == '0));
endmodule

bind beam_mac beam_mac_chk #(.LAT(PRE_DLY + MAC_DLY), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .out_vld(out_vld),
  .out_re(out_re), .out_im(out_im));

// File: tb/sim_beam_mac.sv
module sim_beam_mac;
  localparam int NCH = 10, DW = 12, WW = 16, OW = 16;
  localparam int PRE = 36, LAT = 55, LMAX = 64;

  logic clk = 0, rst = 1, in_vld = 0;
  logic [NCH*DW-1:0] in_re = '0, in_im = '0;
  logic [NCH*WW-1:0] w_re = '0, w_im = '0;
  logic out_vld;
  logic [OW-1:0] out_re, out_im;

  beam_mac u0 (.clk(clk), .rst(rst), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
               .w_re(w_re), .w_im(w_im), .out_vld(out_vld), .out_re(out_re), .out_im(out_im));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit sv [LMAX];
  int xr [LMAX][NCH];
  int xi [LMAX][NCH];
  int wr [LMAX][NCH];
  int wi [LMAX][NCH];

  task automatic check(input string rq, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic longint sat_rnd(input longint s);
    longint r = (s + 8192) >>> 14;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return r;
  endfunction

  function automatic longint exp_part(input int s, input bit im);
    longint acc = 0;
    for (int k = 0; k < NCH; k++)
      if (!im) acc += longint'(xr[s][k]) * wr[s][k] + longint'(xi[s][k]) * wi[s][k];
      else     acc += longint'(xi[s][k]) * wr[s][k] - longint'(xr[s][k]) * wi[s][k];
    return sat_rnd(acc);
  endfunction

  task automatic clear_slots();
    for (int s = 0; s < LMAX; s++) begin
      sv[s] = 0;
      for (int k = 0; k < NCH; k++) begin xr[s][k] = 0; xi[s][k] = 0; wr[s][k] = 0; wi[s][k] = 0; end
    end
  endtask

  task automatic run(input int n, input string rq);
    for (int c = 0; c < n + LAT + 2; c++) begin
      @(negedge clk);
      if (c >= LAT && c - LAT < n && sv[c-LAT]) begin
        check(rq, "out_vld", longint'(out_vld), 1);
        check(rq, "out_re", longint'($signed(out_re)), exp_part(c - LAT, 0));
        check(rq, "out_im", longint'($signed(out_im)), exp_part(c - LAT, 1));
      end else begin
        check(rq, "out_vld idle", longint'(out_vld), 0);
        check("R7", "out_re idle", longint'(out_re), 0);
        check("R7", "out_im idle", longint'(out_im), 0);
      end
      if (c < n) begin
        in_vld = sv[c];
        for (int k = 0; k < NCH; k++) begin
          in_re[k*DW +: DW] = sv[c] ? DW'(xr[c][k]) : DW'($urandom);
          in_im[k*DW +: DW] = sv[c] ? DW'(xi[c][k]) : DW'($urandom);
        end
      end else begin
        in_vld = 0;
        in_re = {NCH{DW'($urandom)}};
        in_im = {NCH{DW'($urandom)}};
      end
      for (int k = 0; k < NCH; k++) begin
        if (c >= PRE && c - PRE < n && sv[c-PRE]) begin
          w_re[k*WW +: WW] = WW'(wr[c-PRE][k]);
          w_im[k*WW +: WW] = WW'(wi[c-PRE][k]);
        end else begin
          w_re[k*WW +: WW] = WW'($urandom);
          w_im[k*WW +: WW] = WW'($urandom);
        end
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R6", "out_vld in reset", longint'(out_vld), 0);
    check("R7", "out_re in reset", longint'(out_re), 0);
    rst = 0;
  endtask

  task automatic t_impulse();
    clear_slots();
    sv[0] = 1;
    for (int k = 0; k < NCH; k++) begin
      xr[0][k] = k*100 - 400; xi[0][k] = 300 - k*50;
      wr[0][k] = 16383 - k*1000; wi[0][k] = k*700 - 3000;
    end
    run(1, "R1 R3 impulse");
  endtask

  task automatic t_align();
    clear_slots();
    sv[1] = 1;
    for (int k = 0; k < NCH; k++) begin
      xr[1][k] = 1500 - k*200; xi[1][k] = k*150 - 700;
      wr[1][k] = 12000 - k*2500; wi[1][k] = 9000 - k*1800;
    end
    run(3, "R2 weight alignment");
  endtask

  task automatic t_stream(input bit gaps);
    clear_slots();
    for (int s = 0; s < 40; s++) begin
      sv[s] = gaps ? 1'($urandom) : 1'b1;
      for (int k = 0; k < NCH; k++) begin
        xr[s][k] = int'($urandom_range(0, 4095)) - 2048;
        xi[s][k] = int'($urandom_range(0, 4095)) - 2048;
        wr[s][k] = int'($urandom_range(0, 65535)) - 32768;
        wi[s][k] = int'($urandom_range(0, 65535)) - 32768;
      end
    end
    run(40, gaps ? "R1 gapped stream" : "R3 back-to-back stream");
  endtask

  task automatic t_sat();
    clear_slots();
    sv[0] = 1; sv[1] = 1;
    for (int k = 0; k < NCH; k++) begin
      xr[0][k] = -2048; xi[0][k] = -2048; wr[0][k] = -16384; wi[0][k] = -16384;
      xr[1][k] = -2048; xi[1][k] = 2047;  wr[1][k] = 16383;  wi[1][k] = -16384;
    end
    run(2, "R5 saturation");
    check("R5", "model high", exp_part(0, 0), 32767);
    check("R5", "model low", exp_part(1, 0), -32768);
  endtask

  task automatic t_round();
    clear_slots();
    for (int s = 0; s < 4; s++) sv[s] = 1;
    xr[0][0] = 1;  wr[0][0] = 8192;
    xr[1][0] = -1; wr[1][0] = 8192;
    xr[2][0] = 1;  wr[2][0] = 8191;
    xr[3][0] = -1; wr[3][0] = 8193;
    check("R4", "tie up", exp_part(0, 0), 1);
    check("R4", "neg tie", exp_part(1, 0), 0);
    check("R4", "below tie", exp_part(2, 0), 0);
    check("R4", "past neg tie", exp_part(3, 0), -1);
    run(4, "R4 rounding");
  endtask

  task automatic t_chan();
    clear_slots();
    sv[0] = 1;
    xr[0][9] = 1000; xi[0][9] = 500; wr[0][9] = 16384;
    xr[0][0] = 0;    wr[0][0] = 16383;
    check("R8", "model ch9 re", exp_part(0, 0), 1000);
    run(1, "R8 channel 9 field");
  endtask

  task automatic t_mid_reset();
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      in_vld = 1;
      in_re = {NCH{DW'($urandom)}};
    end
    @(negedge clk); in_vld = 0; rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      check("R6", "out_vld after reset", longint'(out_vld), 0);
      check("R7", "out_re after reset", longint'(out_re), 0);
    end
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_align();
    t_stream(0);
    t_stream(1);
    t_sat();
    t_round();
    t_chan();
    t_mid_reset();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule